// File: doc/BRIEF.md
# Serial ADC Conversion Master with Periodic Battery Poll

This block runs conversions on an external four-channel serial ADC over a four-wire link: an active-low chip select, a serial clock, a command line toward the converter and a result line back from it. An external start request names a channel. The master drops chip select and sends a command word: a start marker, a single-ended flag, then the channel number least significant bit first. One spare clock pulse follows, and then the master collects an eight-bit result, most significant bit first. Chip select is then released. The byte is written into a small per-channel result store and a one-cycle completion pulse is raised.

The serial clock comes from dividing the system clock. Each half-period lasts a number of system clocks set by a run-time input. A built-in poller converts one fixed channel, the battery channel, as soon as reset ends and again once every configured number of system tick pulses. When a poll request and an external request are both waiting, the poll request is served first. Software or other logic reads any channel's most recent byte through an asynchronous read port.

Top module: `serial_adc_poller`

## Requirements
- R1: While no conversion is running, `adc_cs_n` is 1, `adc_sclk` is 0 and `busy` is 0. This is also the state during reset, and every entry of the result store reads 0 after reset.
- R2: A conversion sends exactly CH_W+2 command bits on `adc_sdi`, in this order: 1 (start), 1 (single-ended), then the channel bits with bit 0 first. Each bit is placed while `adc_sclk` is low and holds unchanged while `adc_sclk` is high, so the converter takes it on the rising edge.
- R3: After the command comes exactly one extra clock pulse with `adc_sdi` at 0, followed by DATA_W data pulses. A conversion therefore has CH_W+3+DATA_W clock pulses (13 with the default widths), and `adc_sdi` is 0 during every pulse after the command.
- R4: During each data pulse, `adc_sdo` is sampled on the system clock edge at which `adc_sclk` falls. The first sample becomes the most significant result bit, and the completed byte appears on `result`.
- R5: Every low and high half of `adc_sclk` lasts `half_div` system clocks, with 0 treated as 1. `adc_cs_n` stays low for exactly 2*(CH_W+3+DATA_W)*`half_div` system clocks.
- R6: In the same cycle that `adc_cs_n` returns high, `done` is 1 for exactly one cycle, with the converted channel on `done_chan`.
- R7: One cycle after `done`, the result store entry for `done_chan` holds `result`, and it reads on `rd_data` when `rd_chan` selects it. The other entries do not change.
- R8: A `start` that arrives while `busy` is 1 is dropped. It starts no later conversion and does not change the channel of the running one.
- R9: The battery channel BATT_CHAN is converted once immediately after reset, and again after every POLL_TICKS pulses of `tick`. A pending poll takes priority over a simultaneous `start`, and that `start` is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_div | input | DIV_W | System clocks per serial clock half-period (0 acts as 1) |
| tick | input | 1 | One-cycle system tick pulse counted by the poller |
| start | input | 1 | Request a conversion of `chan` |
| chan | input | CH_W | Channel for an external request |
| adc_sdo | input | 1 | Result bit from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_sdi | output | 1 | Command bit toward the converter |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_chan | output | CH_W | Channel of the current or last conversion |
| result | output | DATA_W | Byte from the last conversion |
| rd_chan | input | CH_W | Result store read select |
| rd_data | output | DATA_W | Stored byte for `rd_chan` |

## Verification
The hardest case to reach is a collision between the poller and the request port. A pending poll has to be waiting in the very cycle an external `start` arrives. The bench reaches it by sending exactly POLL_TICKS tick pulses and then raising `start` on the next cycle, before the poll has been taken. It then checks that only one conversion follows and that it is on the battery channel. A behavioural converter model watches the link wires on the falling system clock edge. It records the command bits, counts pulses and measures each half-period. It presents result bits that the bench computes for every channel at half-period settings 1 to 3.

// File: rtl/seradc_pkg.sv
package seradc_pkg;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_e;

  // command word: start marker + single-ended flag + channel bits
  localparam int HDR_BITS = 2;
  // spare clock pulses between command and data
  localparam int GAP_PULSES = 1;

endpackage

// File: rtl/seradc_clkdiv.sv
module seradc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             half_end
);

  logic [DIV_W-1:0] hcnt_q, hcnt_d;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit    = (half_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_div;
    half_end = run && (hcnt_q == limit - 1'b1);
    if (!run || half_end) hcnt_d = '0;
    else                  hcnt_d = hcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end

endmodule

// File: rtl/seradc_engine.sv
module seradc_engine
  import seradc_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CH_W-1:0]   go_chan,
  input  logic              half_end,
  input  logic              sdo,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdi,
  output logic              done,
  output logic [CH_W-1:0]   done_chan,
  output logic [DATA_W-1:0] result
);

  localparam int CMD_BITS = HDR_BITS + CH_W;
  localparam int PULSES   = CMD_BITS + GAP_PULSES + DATA_W;
  localparam int HALVES   = 2 * PULSES;
  localparam int PH_W     = $clog2(HALVES);
  localparam logic [PH_W-1:0] PH_LAST    = PH_W'(HALVES - 1);
  localparam logic [PH_W-1:0] DATA_FIRST = PH_W'(CMD_BITS + GAP_PULSES);

  // bit to drive during pulse pidx
  function automatic logic cmd_bit(input logic [PH_W-1:0] pidx,
                                   input logic [CH_W-1:0] ch);
    logic b;
    b = 1'b0;
    if (pidx < PH_W'(HDR_BITS)) b = 1'b1;
    for (int i = 0; i < CH_W; i++)
      if (pidx == PH_W'(HDR_BITS + i)) b = ch[i];
    return b;
  endfunction

  eng_state_e        state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_d, ph_nx, pulse_cur, pulse_nx;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [DATA_W-1:0] shreg_q, shreg_d, shreg_nx;
  logic [DATA_W-1:0] res_q, res_d;
  logic              cs_n_q, cs_n_d;
  logic              sclk_q, sclk_d;
  logic              sdi_q, sdi_d;
  logic              done_q, done_d;

  always_comb begin
    state_d   = state_q;
    ph_d      = ph_q;
    chan_d    = chan_q;
    shreg_d   = shreg_q;
    res_d     = res_q;
    cs_n_d    = cs_n_q;
    sclk_d    = sclk_q;
    sdi_d     = sdi_q;
    done_d    = 1'b0;
    ph_nx     = ph_q + 1'b1;
    pulse_cur = ph_q >> 1;
    pulse_nx  = ph_nx >> 1;
    shreg_nx  = (pulse_cur >= DATA_FIRST) ? {shreg_q[DATA_W-2:0], sdo} : shreg_q;

    if (state_q == ENG_IDLE) begin
      if (go) begin
        state_d = ENG_SHIFT;
        ph_d    = '0;
        chan_d  = go_chan;
        cs_n_d  = 1'b0;
        sclk_d  = 1'b0;
        sdi_d   = cmd_bit('0, go_chan);
        shreg_d = '0;
      end
    end else if (half_end) begin
      if (!ph_q[0]) begin
        // low half over: rising serial edge, command bit stays put
        sclk_d = 1'b1;
        ph_d   = ph_nx;
      end else begin
        // high half over: falling serial edge, sample result line
        sclk_d  = 1'b0;
        shreg_d = shreg_nx;
        if (ph_q == PH_LAST) begin
          state_d = ENG_IDLE;
          ph_d    = '0;
          cs_n_d  = 1'b1;
          sdi_d   = 1'b0;
          done_d  = 1'b1;
          res_d   = shreg_nx;
        end else begin
          ph_d  = ph_nx;
          sdi_d = cmd_bit(pulse_nx, chan_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      ph_q    <= '0;
      chan_q  <= '0;
      shreg_q <= '0;
      res_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      sdi_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      chan_q  <= chan_d;
      shreg_q <= shreg_d;
      res_q   <= res_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      sdi_q   <= sdi_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q == ENG_SHIFT);
  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign sdi       = sdi_q;
  assign done      = done_q;
  assign done_chan = chan_q;
  assign result    = res_q;

endmodule

// File: rtl/seradc_store.sv
module seradc_store #(
  parameter int CH_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NCH = 1 << CH_W;

  logic [DATA_W-1:0] entry_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_entry
    logic              en;
    logic [DATA_W-1:0] entry_d;
    always_comb begin
      en      = wr_en && (wr_chan == CH_W'(g));
      entry_d = en ? wr_data : entry_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[g] <= '0;
      else        entry_q[g] <= entry_d;
    end
  end

  assign rd_data = entry_q[rd_chan];

endmodule

// File: rtl/seradc_poll.sv
module seradc_poll #(
  parameter int POLL_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic taken,
  output logic pend
);

  localparam int CNT_W = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             wrap;

  always_comb begin
    wrap   = tick && (cnt_q == CNT_LAST);
    cnt_d  = cnt_q;
    if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    pend_d = pend_q;
    if (taken) pend_d = 1'b0;
    if (wrap)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;   // first poll right after reset
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/serial_adc_poller.sv
module serial_adc_poller #(
  parameter int CH_W       = 2,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int POLL_TICKS = 100,
  parameter int BATT_CHAN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              tick,
  input  logic              start,
  input  logic [CH_W-1:0]   chan,
  input  logic              adc_sdo,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_sdi,
  output logic              busy,
  output logic              done,
  output logic [CH_W-1:0]   done_chan,
  output logic [DATA_W-1:0] result,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0]      rsync_q;
  logic            rst_sn;
  logic            half_end;
  logic            poll_pend;
  logic            go;
  logic            poll_take;
  logic [CH_W-1:0] go_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  always_comb begin
    go        = !busy && (poll_pend || start);
    poll_take = !busy && poll_pend;
    go_chan   = poll_pend ? CH_W'(BATT_CHAN) : chan;
  end

  seradc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run      (busy),
    .half_div (half_div),
    .half_end (half_end)
  );

  seradc_engine #(.CH_W(CH_W), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sn),
    .go        (go),
    .go_chan   (go_chan),
    .half_end  (half_end),
    .sdo       (adc_sdo),
    .busy      (busy),
    .cs_n      (adc_cs_n),
    .sclk      (adc_sclk),
    .sdi       (adc_sdi),
    .done      (done),
    .done_chan (done_chan),
    .result    (result)
  );

  seradc_store #(.CH_W(CH_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (done),
    .wr_chan (done_chan),
    .wr_data (result),
    .rd_chan (rd_chan),
    .rd_data (rd_data)
  );

  seradc_poll #(.POLL_TICKS(POLL_TICKS)) u_poll (
    .clk   (clk),
    .rst_n (rst_sn),
    .tick  (tick),
    .taken (poll_take),
    .pend  (poll_pend)
  );

endmodule

// File: rtl/serial_adc_poller_chk.sv
module serial_adc_poller_chk #(
  parameter int CH_W   = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_cs_n,
  input logic              adc_sclk,
  input logic              adc_sdi,
  input logic              busy,
  input logic              done,
  input logic [CH_W-1:0]   done_chan,
  input logic [DATA_W-1:0] result,
  input logic [CH_W-1:0]   rd_chan,
  input logic [DATA_W-1:0] rd_data
);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (adc_cs_n && !adc_sclk));

  // R5
  sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);

  // R2
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> $stable(adc_sdi));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> done);

  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(done_chan));

  // R7
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && (rd_chan == $past(done_chan))) |-> (rd_data == $past(result)));

endmodule

bind serial_adc_poller serial_adc_poller_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_cs_n  (adc_cs_n),
  .adc_sclk  (adc_sclk),
  .adc_sdi   (adc_sdi),
  .busy      (busy),
  .done      (done),
  .done_chan (done_chan),
  .result    (result),
  .rd_chan   (rd_chan),
  .rd_data   (rd_data)
);

// File: tb/serial_adc_poller_test.sv
`timescale 1ns/1ps
module serial_adc_poller_test;

  localparam int CH_W = 2, DATA_W = 8, DIV_W = 4, POLL_TICKS = 4, BATT = 3;
  localparam int PULSES = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] half_div = 4'd1;
  logic tick = 1'b0, start = 1'b0, adc_sdo = 1'b0;
  logic [CH_W-1:0] chan = '0, rd_chan = '0;
  logic adc_cs_n, adc_sclk, adc_sdi, busy, done;
  logic [CH_W-1:0] done_chan;
  logic [DATA_W-1:0] result, rd_data;

  always #10 clk = ~clk;

  serial_adc_poller #(.CH_W(CH_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
                      .POLL_TICKS(POLL_TICKS), .BATT_CHAN(BATT)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .tick(tick), .start(start),
    .chan(chan), .adc_sdo(adc_sdo), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_sdi(adc_sdi), .busy(busy), .done(done), .done_chan(done_chan),
    .result(result), .rd_chan(rd_chan), .rd_data(rd_data));

  int checks = 0, failures = 0, cycles = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model, observes the link on the falling system clock edge
  logic [7:0] model_val = 8'h00;
  int xfers = 0, k = 0, since = 0, cslen = 0, last_cslen = 0, hmin = 0, hmax = 0;
  logic [15:0] cmd = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_cs_n && prev_cs) begin
        xfers++; k = 0; since = 1; cslen = 1; hmin = 999; hmax = 0; adc_sdo = 1'b0;
      end else if (!adc_cs_n) begin
        cslen++;
        if (adc_sclk != prev_sclk) begin
          if (since < hmin) hmin = since;
          if (since > hmax) hmax = since;
          since = 1;
        end else since++;
      end else if (!prev_cs) begin
        if (since < hmin) hmin = since;
        if (since > hmax) hmax = since;
        last_cslen = cslen;
      end
      if (adc_sclk && !prev_sclk) begin
        if (k < 16) cmd[k] = adc_sdi;
        if (k >= 5 && k < 13) adc_sdo = model_val[12-k];
        k++;
      end
    end
    prev_cs   = adc_cs_n;
    prev_sclk = adc_sclk;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [7:0] exp_store [4];

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  // after done seen at a negedge: verify the finished frame one cycle later
  task automatic verify_frame(input int ch, input int val, input int d);
    check(result == 8'(val), "R4 result", result, val);
    check(done_chan == 2'(ch), "R6 done_chan", done_chan, ch);
    check(adc_cs_n == 1'b1, "R6 cs_n high with done", adc_cs_n, 1);
    rd_chan = 2'(ch);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
    check(k == PULSES, "R3 pulse count", k, PULSES);
    check(cmd[0] == 1'b1 && cmd[1] == 1'b1, "R2 start and single-ended", int'(cmd[1:0]), 3);
    check(cmd[2] == ch[0] && cmd[3] == ch[1], "R2 channel lsb first", int'(cmd[3:2]),
          int'({ch[0], ch[1]}) == 0 ? 0 : ((ch & 1) | ((ch >> 1) << 1)));
    check(cmd[12:4] == 9'd0, "R3 gap and data pulses sdi low", int'(cmd[12:4]), 0);
    check(hmin == d && hmax == d, "R5 half period", hmax, d);
    check(last_cslen == 2 * PULSES * d, "R5 cs low length", last_cslen, 2 * PULSES * d);
    check(rd_data == 8'(val), "R7 store read", rd_data, val);
    exp_store[ch] = 8'(val);
  endtask

  task automatic xfer(input int ch, input int val, input int d);
    half_div  = DIV_W'(d);
    model_val = 8'(val);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; chan = 2'(ch);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    verify_frame(ch, val, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    int x0;
    model_val = 8'hA6;
    half_div  = 4'd2;
    repeat (4) @(negedge clk);
    check(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1 reset lines", {adc_cs_n, adc_sclk}, 2);
    check(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {busy, done}, 0);
    for (int c = 0; c < 4; c++) begin
      rd_chan = 2'(c); #1;
      check(rd_data == 8'h00, "R1 store cleared", rd_data, 0);
    end
    rst_n = 1'b1;
    // R9: poll of the battery channel right after reset
    wait_done();
    check(done_chan == 2'(BATT), "R9 first poll channel", done_chan, BATT);
    verify_frame(BATT, 8'hA6, 2);

    // sweep: half period 0..3, all channels, two values each
    for (int d = 0; d <= 3; d++)
      for (int c = 0; c < 4; c++)
        for (int n = 0; n < 2; n++)
          xfer(c, ((c * 37 + d * 91 + n * 113) ^ 8'h5A) & 8'hFF, (d == 0) ? 1 : d);
    // half_div 0 behaves as 1 (the d=0 rows above use 1; now drive a real 0)
    half_div = 4'd0; model_val = 8'h81;
    @(negedge clk); start = 1'b1; chan = 2'd1; @(negedge clk); start = 1'b0;
    wait_done();
    verify_frame(1, 8'h81, 1);

    // R7: all entries hold their last values
    for (int c = 0; c < 4; c++) begin
      rd_chan = 2'(c); #1;
      check(rd_data == exp_store[c], "R7 store isolation", rd_data, exp_store[c]);
    end

    // R8: start during busy dropped
    half_div = 4'd2; model_val = 8'h3C;
    @(negedge clk); start = 1'b1; chan = 2'd0; @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    x0 = xfers;
    start = 1'b1; chan = 2'd2; @(negedge clk); start = 1'b0;
    check(done_chan == 2'd0, "R8 channel unchanged", done_chan, 0);
    wait_done();
    verify_frame(0, 8'h3C, 2);
    repeat (120) @(negedge clk);
    check(xfers == x0, "R8 no later conversion", xfers, x0);
    rd_chan = 2'd2; #1;
    check(rd_data == exp_store[2], "R8 other entry untouched", rd_data, exp_store[2]);

    // R9: period of POLL_TICKS ticks
    model_val = 8'hC3; x0 = xfers;
    ticks(POLL_TICKS - 1);
    repeat (100) @(negedge clk);
    check(xfers == x0, "R9 no poll before period", xfers, x0);
    ticks(1);
    wait_done();
    check(done_chan == 2'(BATT), "R9 periodic poll channel", done_chan, BATT);
    verify_frame(BATT, 8'hC3, 2);

    // R9: poll wins over a start in the same cycle
    model_val = 8'h5E; x0 = xfers;
    for (int i = 0; i < POLL_TICKS - 1; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    start = 1'b1; chan = 2'd0; @(negedge clk); start = 1'b0;
    wait_done();
    check(done_chan == 2'(BATT), "R9 poll priority", done_chan, BATT);
    verify_frame(BATT, 8'h5E, 2);
    repeat (120) @(negedge clk);
    check(xfers == x0 + 1, "R9 colliding start dropped", xfers, x0 + 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule